// File: doc/BRIEF.md
# Multi-Mode Programmable Register Cell

This block is one storage bit whose behaviour is chosen by configuration inputs. It can act as a D, toggle, JK or set/reset flip-flop, or as a flow-through latch. Its data comes from one of three candidate sources: an XOR result, a separate product term, or a pin input. Its clock is one of several global clocks or a product-term clock. A product-term clock enable can gate the global clocks. An asynchronous clear and an asynchronous preset each come from a configurable source.

All candidate clocks are treated as level signals and sampled on the block's own system clock `clk`. That clock must run faster than any candidate clock. A rising edge of the selected clock is seen as a low sample followed by a high sample. The asynchronous clear, the asynchronous preset and the open latch reach the output `q` through combinational paths, in the same cycle. Each of them also loads the stored state at the next `clk` edge. Logic generation and signal routing are outside this block.

Top module: `mmreg_cell`

## Requirements
- R1: A low `rst_n` at a `clk` edge sets the stored state to 0 and sets the remembered clock level to 0. With no clear, no preset and no open latch, `q` then reads 0.
- R2: Data source `cfg_dsel`: 0 = `xor_in`, 1 = `pt_data`, 2 = `pin_in`, 3 = `xor_in`.
- R3: In D mode (`cfg_mode` = 0), an enabled rising edge of the selected clock loads the selected data. No other `clk` edge changes the state. A rising edge is a `clk` edge at which the selected clock is sampled high after being sampled low at the previous edge.
- R4: In toggle mode (`cfg_mode` = 1), an enabled rising edge inverts the state when the selected data is 1 and holds it when the data is 0.
- R5: In JK mode (`cfg_mode` = 2), J is the selected data and K is `aux_in`. On an enabled rising edge the inputs act as follows: 10 sets, 01 clears, 00 holds, 11 toggles.
- R6: In set/reset mode (`cfg_mode` = 3), S is the selected data and R is `aux_in`. On an enabled rising edge, S alone sets, R alone clears, and S and R together clear.
- R7: In latch mode (`cfg_mode` = 4), `q` equals the selected data in any cycle where the selected clock is high, and the state follows that data. While the clock is low, the state holds. The clock enable has no effect in this mode.
- R8: Clock source `cfg_csel`: values 0 to 2 pick `gclk_in[0]` to `gclk_in[2]`, and 3 picks `pt_clk`.
- R9: With `cfg_ce_on` = 1 and a global clock selected, edges that occur while `pt_ce` is low are ignored. When `pt_clk` is selected, `pt_ce` has no effect.
- R10: Clear source `cfg_clr_src`: bit 0 enables `gclr` and bit 1 enables `pt_clr`. An active clear drives `q` to 0 in the same cycle and loads 0 at the next `clk` edge.
- R11: With `cfg_pre_on` = 1, a high `pt_pre` drives `q` to 1 in the same cycle and loads 1 at the next `clk` edge. With `cfg_pre_on` = 0, `pt_pre` is ignored.
- R12: When clear and preset are active together, clear wins.
- R13: Mode codes 5, 6 and 7 behave exactly like D mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Storage behaviour select |
| cfg_dsel | input | 2 | Data source select |
| cfg_csel | input | 2 | Clock source select |
| cfg_ce_on | input | 1 | Use `pt_ce` as clock enable for global clocks |
| cfg_clr_src | input | 2 | Clear source enables |
| cfg_pre_on | input | 1 | Preset source enable |
| xor_in | input | 1 | Data candidate: XOR result |
| pt_data | input | 1 | Data candidate: separate product term |
| pin_in | input | 1 | Data candidate: pin input |
| aux_in | input | 1 | K input in JK mode, R input in set/reset mode |
| gclk_in | input | 3 | Global clock candidates |
| pt_clk | input | 1 | Product-term clock candidate |
| pt_ce | input | 1 | Product-term clock enable |
| gclr | input | 1 | Global clear |
| pt_clr | input | 1 | Product-term clear |
| pt_pre | input | 1 | Product-term preset |
| q | output | 1 | Stored state, after clear, preset and latch pass-through |

## Verification
A corrupted stored bit is not visible at once when a clear, a preset or an open latch is driving `q`. It shows up in the first cycle after these paths are released. A wrong remembered clock level shows up differently. It causes an edge to be taken that should not be, or an edge to be missed. The effect then appears at `q` one `clk` cycle after the sampled edge. In toggle and JK-toggle operation, a single bad update keeps `q` inverted until the next load.

// File: rtl/mmreg_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the multi-mode register cell.
// Assumes a 3-bit mode field; codes beyond LATCH fall back to D behaviour.
package mmreg_pkg;
    localparam int MODE_W = 3;
    localparam int DSEL_W = 2;
    localparam int CLRS_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_D     = 3'd0,
        MODE_T     = 3'd1,
        MODE_JK    = 3'd2,
        MODE_SR    = 3'd3,
        MODE_LATCH = 3'd4
    } cell_mode_e;

    localparam logic [DSEL_W-1:0] DSEL_PT  = 2'd1;
    localparam logic [DSEL_W-1:0] DSEL_PIN = 2'd2;
endpackage

// File: rtl/mmreg_src_sel.sv
`timescale 1ns/1ps
// Module: mmreg_src_sel
// Picks the data candidate and the clock candidate, and decides whether
// the clock enable currently allows edges.
// Assumes: select codes at or above NGCLK choose the product-term clock;
// the enable gates only global clocks.
module mmreg_src_sel
    import mmreg_pkg::*;
#(
    parameter int NGCLK = 3,
    localparam int CSEL_W = $clog2(NGCLK + 1)
) (
    input  logic [DSEL_W-1:0] cfg_dsel,
    input  logic [CSEL_W-1:0] cfg_csel,
    input  logic              cfg_ce_on,
    input  logic              xor_in,
    input  logic              pt_data,
    input  logic              pin_in,
    input  logic [NGCLK-1:0]  gclk_in,
    input  logic              pt_clk,
    input  logic              pt_ce,
    output logic              d_sel,
    output logic              clk_sel,
    output logic              ce_ok
);
    logic [NGCLK-1:0] clk_hit;
    logic             use_pt_clk;

    // One match term per global clock; at most one can be set.
    for (genvar g = 0; g < NGCLK; g++) begin : g_clk_hit
        assign clk_hit[g] = (cfg_csel == CSEL_W'(g)) & gclk_in[g];
    end

    assign use_pt_clk = (cfg_csel >= CSEL_W'(NGCLK));

    // Data candidate mux.
    always_comb begin
        unique case (cfg_dsel)
            DSEL_PT:  d_sel = pt_data;
            DSEL_PIN: d_sel = pin_in;
            default:  d_sel = xor_in;
        endcase
    end

    // Clock candidate mux and enable qualification.
    always_comb begin
        clk_sel = use_pt_clk ? pt_clk : |clk_hit;
        ce_ok   = use_pt_clk | ~cfg_ce_on | pt_ce;
    end
endmodule

// File: rtl/mmreg_edge.sv
`timescale 1ns/1ps
// Module: mmreg_edge
// Detects an enabled rising edge of the selected clock by comparing it
// against its level at the previous system clock edge.
// Assumes: the selected clock is slower than clk; reset clears the
// remembered level.
module mmreg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel,
    input  logic ce_ok,
    output logic rise
);
    logic clk_prev;

    // Remember the sampled level of the selected clock.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_sel;
    end

    assign rise = clk_sel & ~clk_prev & ce_ok;
endmodule

// File: rtl/mmreg_next.sv
`timescale 1ns/1ps
// Module: mmreg_next
// Computes the state after an edge for each edge-triggered mode.
// Assumes: d is J or S, aux is K or R; JK 11 toggles, SR 11 clears.
module mmreg_next
    import mmreg_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              cur,
    input  logic              d,
    input  logic              aux,
    output logic              nxt
);
    // Next-state function per mode; unlisted codes behave as D.
    always_comb begin
        unique case (cell_mode_e'(mode))
            MODE_T:  nxt = cur ^ d;
            MODE_JK: nxt = (d & ~cur) | (~aux & cur);
            MODE_SR: nxt = ~aux & (d | cur);
            default: nxt = d;
        endcase
    end
endmodule

// File: rtl/mmreg_async.sv
`timescale 1ns/1ps
// Module: mmreg_async
// Resolves the asynchronous clear and preset from their configured sources.
// Assumes: clear-source bit 0 enables the global clear, bit 1 the product term.
module mmreg_async
    import mmreg_pkg::*;
(
    input  logic [CLRS_W-1:0] cfg_clr_src,
    input  logic              cfg_pre_on,
    input  logic              gclr,
    input  logic              pt_clr,
    input  logic              pt_pre,
    output logic              clr_act,
    output logic              pre_act
);
    // Gate each source by its enable and combine the clears.
    always_comb begin
        clr_act = (cfg_clr_src[0] & gclr) | (cfg_clr_src[1] & pt_clr);
        pre_act = cfg_pre_on & pt_pre;
    end
endmodule

// File: rtl/mmreg_cell.sv
`timescale 1ns/1ps
// Module: mmreg_cell (top)
// One configurable storage bit: D, toggle, JK, set/reset or flow-through latch,
// with selectable data, clock, enable, clear and preset sources.
// Assumes: candidate clocks are sampled on clk; clear beats preset, which
// beats latch pass-through and stored state at the output.
module mmreg_cell
    import mmreg_pkg::*;
#(
    parameter int NGCLK = 3,
    localparam int CSEL_W = $clog2(NGCLK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [DSEL_W-1:0] cfg_dsel,
    input  logic [CSEL_W-1:0] cfg_csel,
    input  logic              cfg_ce_on,
    input  logic [CLRS_W-1:0] cfg_clr_src,
    input  logic              cfg_pre_on,
    input  logic              xor_in,
    input  logic              pt_data,
    input  logic              pin_in,
    input  logic              aux_in,
    input  logic [NGCLK-1:0]  gclk_in,
    input  logic              pt_clk,
    input  logic              pt_ce,
    input  logic              gclr,
    input  logic              pt_clr,
    input  logic              pt_pre,
    output logic              q
);
    logic d_sel, clk_sel, ce_ok, rise, nxt, clr_act, pre_act, latch_mode, state;

    mmreg_src_sel #(.NGCLK(NGCLK)) src_i (
        .cfg_dsel(cfg_dsel), .cfg_csel(cfg_csel), .cfg_ce_on(cfg_ce_on),
        .xor_in(xor_in), .pt_data(pt_data), .pin_in(pin_in),
        .gclk_in(gclk_in), .pt_clk(pt_clk), .pt_ce(pt_ce),
        .d_sel(d_sel), .clk_sel(clk_sel), .ce_ok(ce_ok)
    );

    mmreg_edge edge_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ce_ok(ce_ok), .rise(rise)
    );

    mmreg_next next_i (
        .mode(cfg_mode), .cur(state), .d(d_sel), .aux(aux_in), .nxt(nxt)
    );

    mmreg_async async_i (
        .cfg_clr_src(cfg_clr_src), .cfg_pre_on(cfg_pre_on), .gclr(gclr),
        .pt_clr(pt_clr), .pt_pre(pt_pre), .clr_act(clr_act), .pre_act(pre_act)
    );

    assign latch_mode = (cell_mode_e'(cfg_mode) == MODE_LATCH);

    // Stored state update: reset, then clear, preset, latch, edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   state <= 1'b0;
        else if (clr_act)             state <= 1'b0;
        else if (pre_act)             state <= 1'b1;
        else if (latch_mode)          state <= clk_sel ? d_sel : state;
        else if (rise)                state <= nxt;
    end

    // Output: asynchronous overrides and latch pass-through ahead of state.
    always_comb begin
        if (clr_act)                      q = 1'b0;
        else if (pre_act)                 q = 1'b1;
        else if (latch_mode && clk_sel)   q = d_sel;
        else                              q = state;
    end
endmodule

// File: rtl/mmreg_cell_chk.sv
`timescale 1ns/1ps
// Module: mmreg_cell_chk
// Port-level properties of the register cell, bound to every mmreg_cell.
// Assumes the same encodings as the cell; recomputes selections from ports.
module mmreg_cell_chk
    import mmreg_pkg::*;
#(
    parameter int NGCLK = 3,
    localparam int CSEL_W = $clog2(NGCLK + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] cfg_mode,
    input logic [DSEL_W-1:0] cfg_dsel,
    input logic [CSEL_W-1:0] cfg_csel,
    input logic              cfg_ce_on,
    input logic [CLRS_W-1:0] cfg_clr_src,
    input logic              cfg_pre_on,
    input logic              xor_in,
    input logic              pt_data,
    input logic              pin_in,
    input logic [NGCLK-1:0]  gclk_in,
    input logic              pt_clk,
    input logic              pt_ce,
    input logic              gclr,
    input logic              pt_clr,
    input logic              pt_pre,
    input logic              q
);
    logic ck_now, d_now, clr_on, pre_on, quiet, en_ok, gated;

    // Rebuild the observable selections from the ports.
    always_comb begin
        ck_now = pt_clk;
        for (int i = 0; i < NGCLK; i++)
            if (cfg_csel == CSEL_W'(i)) ck_now = gclk_in[i];
        d_now  = (cfg_dsel == 2'd1) ? pt_data : (cfg_dsel == 2'd2) ? pin_in : xor_in;
        clr_on = (cfg_clr_src[0] && gclr) || (cfg_clr_src[1] && pt_clr);
        pre_on = cfg_pre_on && pt_pre;
        quiet  = !clr_on && !pre_on;
        en_ok  = (cfg_csel >= CSEL_W'(NGCLK)) || !cfg_ce_on || pt_ce;
        gated  = !en_ok && cfg_mode != 3'd4;
    end

    p_clear_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_on |-> !q);

    p_preset_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_on && !clr_on) |-> q);

    p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on && pre_on) |-> !q);

    p_latch_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 3'd4 && ck_now && quiet) |-> (q == d_now));

    p_gated_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && quiet) ##1 (quiet && cfg_mode != 3'd4) |-> $stable(q));

    p_d_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 3'd0 && quiet && en_ok && ck_now && !$past(ck_now))
        |=> (!quiet || cfg_mode == 3'd4 || q == $past(d_now)));

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && quiet && cfg_mode != 3'd4) |-> !q);
endmodule

bind mmreg_cell mmreg_cell_chk #(.NGCLK(NGCLK)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dsel(cfg_dsel),
    .cfg_csel(cfg_csel), .cfg_ce_on(cfg_ce_on), .cfg_clr_src(cfg_clr_src),
    .cfg_pre_on(cfg_pre_on), .xor_in(xor_in), .pt_data(pt_data),
    .pin_in(pin_in), .gclk_in(gclk_in), .pt_clk(pt_clk), .pt_ce(pt_ce),
    .gclr(gclr), .pt_clr(pt_clr), .pt_pre(pt_pre), .q(q)
);

// File: tb/mmreg_cell_tb_top.sv
`timescale 1ns/1ps
// Bench: drives the cell each cycle at the falling edge and compares q with a
// behavioural model that advances once per rising edge.
module mmreg_cell_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic [1:0] cfg_dsel = '0, cfg_csel = '0, cfg_clr_src = '0;
    logic       cfg_ce_on = 1'b0, cfg_pre_on = 1'b0;
    logic       xor_in = 0, pt_data = 0, pin_in = 0, aux_in = 0;
    logic [2:0] gclk_in = '0;
    logic       pt_clk = 0, pt_ce = 0, gclr = 0, pt_clr = 0, pt_pre = 0;
    logic       q;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    bit m_state = 1'b0;
    bit m_prev  = 1'b0;

    always #4 clk = ~clk;

    mmreg_cell dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dsel(cfg_dsel),
        .cfg_csel(cfg_csel), .cfg_ce_on(cfg_ce_on), .cfg_clr_src(cfg_clr_src),
        .cfg_pre_on(cfg_pre_on), .xor_in(xor_in), .pt_data(pt_data),
        .pin_in(pin_in), .aux_in(aux_in), .gclk_in(gclk_in), .pt_clk(pt_clk),
        .pt_ce(pt_ce), .gclr(gclr), .pt_clr(pt_clr), .pt_pre(pt_pre), .q(q)
    );

    function automatic bit edge_result(int mode, bit s, bit d, bit a);
        case (mode)
            1: return s ^ d;                                   // R4
            2: return (d && a) ? !s : (d ? 1'b1 : (a ? 1'b0 : s)); // R5
            3: return a ? 1'b0 : (d ? 1'b1 : s);               // R6
            default: return d;                                 // R3, R13
        endcase
    endfunction

    // One cycle: drive, check q against the model, then advance the model.
    task automatic step(string tag, bit rst_v, int mode, int dsel, int csel,
                        bit ce_on, int clrs, bit pre_on, int async_rate);
        bit dsrc, ck, clr, pre, exp_q, ce_ok;
        @(negedge clk);
        rst_n = rst_v; cfg_mode = 3'(mode); cfg_dsel = 2'(dsel);
        cfg_csel = 2'(csel); cfg_ce_on = ce_on; cfg_clr_src = 2'(clrs);
        cfg_pre_on = pre_on;
        xor_in = 1'($urandom); pt_data = 1'($urandom); pin_in = 1'($urandom);
        aux_in = 1'($urandom); gclk_in = 3'($urandom); pt_clk = 1'($urandom);
        pt_ce = 1'($urandom);
        gclr   = (async_rate > 0) && ($urandom % async_rate == 0);
        pt_clr = (async_rate > 0) && ($urandom % async_rate == 0);
        pt_pre = (async_rate > 0) && ($urandom % async_rate == 0);
        #1;
        dsrc = (dsel == 1) ? pt_data : (dsel == 2) ? pin_in : xor_in;
        ck   = (csel < 3) ? gclk_in[csel] : pt_clk;
        clr  = (clrs[0] && gclr) || (clrs[1] && pt_clr);
        pre  = pre_on && pt_pre;
        if (clr) exp_q = 0;
        else if (pre) exp_q = 1;
        else if (mode == 4 && ck) exp_q = dsrc;
        else exp_q = m_state;
        tests++;
        if (q !== exp_q) begin
            fails++;
            $display("FAIL %s: q=%0b expected %0b (mode %0d dsel %0d csel %0d) at %0t",
                     tag, q, exp_q, mode, dsel, csel, $time);
        end
        if (!rst_v) begin
            m_state = 0; m_prev = 0;
        end else begin
            ce_ok = (csel >= 3) || !ce_on || pt_ce;
            if (clr) m_state = 0;
            else if (pre) m_state = 1;
            else if (mode == 4) begin
                if (ck) m_state = dsrc;
            end else if (ck && !m_prev && ce_ok)
                m_state = edge_result(mode, m_state, dsrc, aux_in);
            m_prev = ck;
        end
    endtask

    task automatic phase(string tag, int n, int mode, int dsel, int csel,
                         bit ce_on, int clrs, bit pre_on, int rate);
        for (int i = 0; i < n; i++)
            step(tag, 1'b1, mode, dsel, csel, ce_on, clrs, pre_on, rate);
    endtask

    initial begin
        // R1: reset held, then released with no async sources.
        for (int i = 0; i < 4; i++) step("R1", 1'b0, 0, 0, 0, 0, 0, 0, 0);
        phase("R1", 2, 0, 0, 0, 0, 0, 0, 0);
        phase("R3", 60, 0, 0, 0, 0, 0, 0, 0);
        phase("R2", 40, 0, 1, 0, 0, 0, 0, 0);
        phase("R2", 40, 0, 2, 0, 0, 0, 0, 0);
        phase("R2", 40, 0, 3, 0, 0, 0, 0, 0);
        phase("R4", 60, 1, 0, 0, 0, 0, 0, 0);
        phase("R5", 80, 2, 1, 0, 0, 0, 0, 0);
        phase("R6", 80, 3, 2, 0, 0, 0, 0, 0);
        phase("R7", 60, 4, 0, 0, 1, 0, 0, 0);
        phase("R8", 40, 0, 0, 1, 0, 0, 0, 0);
        phase("R8", 40, 1, 0, 2, 0, 0, 0, 0);
        phase("R8", 40, 0, 0, 3, 0, 0, 0, 0);
        phase("R9", 60, 1, 0, 2, 1, 0, 0, 0);
        phase("R9", 60, 1, 0, 3, 1, 0, 0, 0);
        phase("R10", 40, 1, 0, 0, 0, 1, 0, 3);
        phase("R10", 40, 1, 0, 0, 0, 2, 0, 3);
        phase("R10", 40, 4, 0, 0, 0, 3, 0, 3);
        phase("R11", 40, 1, 0, 0, 0, 0, 1, 3);
        phase("R11", 40, 1, 0, 0, 0, 0, 0, 2);
        phase("R12", 60, 1, 0, 0, 0, 3, 1, 2);
        phase("R13", 40, 5, 0, 0, 0, 0, 0, 0);
        phase("R13", 40, 6, 1, 1, 0, 0, 0, 0);
        phase("R13", 40, 7, 2, 3, 0, 0, 0, 0);
        // Full sweep: every mode and source combination, switched per cycle.
        for (int i = 0; i < 3000; i++) begin
            int md = int'($urandom % 8);
            string tg;
            case (md)
                0: tg = "R3"; 1: tg = "R4"; 2: tg = "R5";
                3: tg = "R6"; 4: tg = "R7"; default: tg = "R13";
            endcase
            step(tg, 1'b1, md, int'($urandom % 4), int'($urandom % 4),
                 1'($urandom), int'($urandom % 4), 1'($urandom), 6);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule